// File: doc/BRIEF.md
# Byte-Wide Serial Port Controller with Prioritised Interrupts

This block is a register-mapped asynchronous serial port for a host that talks to it over a 3-bit address and an 8-bit data bus with separate read and write strobes. The host uses it to pick a frame format and a bit rate and to move bytes one at a time. There is a single holding byte in each direction and no queue. A programmable 16-bit divisor produces a sampling tick at sixteen times the bit rate. The transmit and receive engines count sixteen ticks per bit, so one tick per clock gives sixteen clocks per bit.

Interrupt events come from four sources: a receive error, a received byte, an empty transmit holding byte, and a change on the handshake inputs. They are ranked by a fixed priority and reported through an identification register. A single interrupt pin is driven only while a gating bit in the modem control register is set. A loopback mode turns the port back on itself so that the host can test it without external wiring.

Top module: `sport_top`

## Requirements
- R1: Registers sit at these offsets: 0 data, 1 interrupt enable (bits 3:0), 2 identification (read only), 3 line control, 4 modem control (bits 4:0), 5 line status (read only), 6 modem status (read only) and 7 scratch. The line control, modem control, enable and scratch registers read back what was written. Outside loopback, modem control bit 0 drives `dtr_out`, bit 1 drives `rts_out`, bit 2 drives `out1_out` and bit 3 drives `out2_out`.
- R2: While line control bit 7 is 1, offset 0 reads and writes the low divisor byte and offset 1 reads and writes the high divisor byte. The data and enable registers are left unchanged. The divisor resets to 0, and a divisor of 0 stops the bit clock.
- R3: A transmitted frame is a 0 start bit, then 5 + LCR[1:0] data bits sent LSB first, then a parity bit when LCR[3] is 1, then one stop bit of 1, or two when LCR[2] is 1. When LCR[5] is 1 the parity bit is the inverse of LCR[4]. Otherwise it makes the count of ones even when LCR[4] is 1 and odd when LCR[4] is 0.
- R4: While LCR[6] is 1 and loopback is off, `ser_out` is held at 0.
- R5: A received byte sets line status bit 0 and is read at offset 0. That read clears bit 0.
- R6: A parity mismatch sets line status bit 2 and a 0 stop bit sets line status bit 3. Reading the line status clears bits 1, 2 and 3.
- R7: A byte that arrives while bit 0 is still set sets line status bit 1 and replaces the held byte.
- R8: The identification register reads 0x01 when nothing enabled is pending. Otherwise it reads the code of the highest-ranked pending source: 0x06 for a receive error (enable bit 2), 0x04 for received data (bit 0), 0x02 for transmit empty (bit 1) and 0x00 for a modem change (bit 3).
- R9: The transmit-empty event is set when the holding byte moves into the shifter, or when enable bit 1 is turned on while the holding byte is empty. It is cleared by a write to the data register, or by a read of the identification register while that register shows 0x02.
- R10: `irq` is 1 only when a source is pending and modem control bit 3 is 1.
- R11: Modem status bits 7:4 hold DCD, RI, DSR and CTS. Bits 0, 1 and 3 flag a change on CTS, DSR and DCD, and bit 2 flags a 1-to-0 transition on RI. Reading the modem status clears bits 3:0.
- R12: When modem control bit 4 is 1, the transmitter feeds the receiver and `ser_out` stays at 1. The modem outputs read 0, and DTR, RTS, OUT1 and OUT2 appear as DSR, CTS, RI and DCD.
- R13: Line status bit 5 is 1 while the transmit holding byte is empty, and bit 6 is 1 while both the holding byte and the shifter are empty. After reset the line status reads 0x60 and the identification register reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe; triggers clear-on-read effects |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq | output | 1 | Interrupt request |
| ser_in | input | 1 | Serial receive line |
| ser_out | output | 1 | Serial transmit line |
| cts_in | input | 1 | Clear-to-send input |
| dsr_in | input | 1 | Data-set-ready input |
| ri_in | input | 1 | Ring indicator input |
| dcd_in | input | 1 | Carrier detect input |
| dtr_out | output | 1 | Terminal-ready output |
| rts_out | output | 1 | Request-to-send output |
| out1_out | output | 1 | General output 1 |
| out2_out | output | 1 | General output 2 (also gates `irq`) |

## Verification
The assertions assume that the host holds `addr` steady while a strobe is high and never raises `wr_en` and `rd_en` in the same cycle. They also assume that the frame format is not rewritten while a frame is in flight, because the receiver decodes with the live line control value. The stimulus obeys these rules: every access is one strobe cycle driven on the falling edge, and a frame is always allowed to finish before the line control register is changed. The handshake inputs are changed only between register accesses, and every test uses a divisor of 1.

// File: rtl/sport_pkg.sv
// Package: shared offsets, frame state encoding and parity helper for the
// serial port. Assumes an 8-bit data bus and a 3-bit register offset.
package sport_pkg;

    localparam logic [2:0] OFF_DATA = 3'd0;
    localparam logic [2:0] OFF_IER  = 3'd1;
    localparam logic [2:0] OFF_IIR  = 3'd2;
    localparam logic [2:0] OFF_LCR  = 3'd3;
    localparam logic [2:0] OFF_MCR  = 3'd4;
    localparam logic [2:0] OFF_LSR  = 3'd5;
    localparam logic [2:0] OFF_MSR  = 3'd6;
    localparam logic [2:0] OFF_SCR  = 3'd7;

    localparam logic [2:0] CODE_LINE = 3'b110;
    localparam logic [2:0] CODE_RXD  = 3'b100;
    localparam logic [2:0] CODE_THRE = 3'b010;
    localparam logic [2:0] CODE_MDM  = 3'b000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } frame_state_t;

    // Parity bit for a word of 5 + wlen bits (upper bits masked off).
    function automatic logic frame_parity(input logic [7:0] d, input logic [1:0] wlen,
                                          input logic even, input logic stick);
        logic [7:0] mask;
        logic       ones;
        mask = 8'hFF >> (2'd3 - wlen);
        ones = ^(d & mask);
        if (stick) return !even;
        return even ? ones : !ones;
    endfunction

endpackage

// File: rtl/sport_baud.sv
// Bit-clock generator: emits one tick every DIVISOR clocks (the 16x
// oversampling rate). Assumes divisor 0 means stopped.
module sport_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    // End of the divide window; never true while the divisor is zero.
    assign at_end = (divisor != '0) && (cnt_q >= divisor - DIV_W'(1));
    assign tick   = at_end;

    // Free-running divide counter, held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (divisor == '0)  cnt_q <= '0;
        else if (at_end)         cnt_q <= '0;
        else                     cnt_q <= cnt_q + DIV_W'(1);
    end
endmodule

// File: rtl/sport_tx.sv
// Transmit shifter: takes a byte from the holding register on a tick while
// idle and sends start, data (LSB first), optional parity and stop bits,
// each OVS ticks long. Assumes the format is sampled at load time.
module sport_tx
    import sport_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic [7:0] data,
    input  logic [1:0] wlen,
    input  logic       stop2,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    output logic       take,
    output logic       line,
    output logic       busy
);
    localparam int SUB_W = $clog2(OVS);

    frame_state_t     st_q;
    logic [SUB_W-1:0] sub_q;
    logic [2:0]       bitn_q, last_q;
    logic [7:0]       sh_q;
    logic             pbit_q, pen_q, two_q, second_q;
    logic             bit_end;

    assign take    = tick && (st_q == ST_IDLE) && load;
    assign bit_end = tick && (sub_q == SUB_W'(OVS - 1));
    assign busy    = (st_q != ST_IDLE);

    // Line level for the bit currently being sent.
    always_comb begin
        unique case (st_q)
            ST_START: line = 1'b0;
            ST_DATA:  line = sh_q[0];
            ST_PAR:   line = pbit_q;
            default:  line = 1'b1;
        endcase
    end

    // Frame sequencer: loads a byte, then steps through the bit positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE; sub_q <= '0; bitn_q <= '0; last_q <= '0; sh_q <= '0;
            pbit_q <= 1'b0; pen_q <= 1'b0; two_q <= 1'b0; second_q <= 1'b0;
        end else if (take) begin
            st_q     <= ST_START;
            sub_q    <= '0;
            sh_q     <= data;
            pbit_q   <= frame_parity(data, wlen, par_even, par_stick);
            last_q   <= {1'b0, wlen} + 3'd4;
            pen_q    <= par_en;
            two_q    <= stop2;
            second_q <= 1'b0;
        end else if (busy && tick) begin
            if (!bit_end) begin
                sub_q <= sub_q + SUB_W'(1);
            end else begin
                sub_q <= '0;
                unique case (st_q)
                    ST_START: begin st_q <= ST_DATA; bitn_q <= '0; end
                    ST_DATA: begin
                        sh_q <= sh_q >> 1;
                        if (bitn_q == last_q) st_q <= pen_q ? ST_PAR : ST_STOP;
                        else                  bitn_q <= bitn_q + 3'd1;
                    end
                    ST_PAR: st_q <= ST_STOP;
                    ST_STOP: begin
                        if (two_q && !second_q) second_q <= 1'b1;
                        else                    st_q <= ST_IDLE;
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sport_rx.sv
// Receive engine: finds a falling start edge (only after the line has been
// seen high), confirms it at mid-bit, samples each later bit at its middle
// and pulses done with data and error flags after the stop bit.
// Assumes the format is not changed during a frame.
module sport_rx
    import sport_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] wlen,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    output logic       done,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr
);
    localparam int SUB_W = $clog2(OVS);

    frame_state_t     st_q;
    logic [SUB_W-1:0] sub_q;
    logic [2:0]       bitn_q, last;
    logic [7:0]       sh_q, aligned;
    logic             prx_q, armed_q;

    assign last    = {1'b0, wlen} + 3'd4;
    assign aligned = sh_q >> (2'd3 - wlen);

    // Frame receiver and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE; sub_q <= '0; bitn_q <= '0; sh_q <= '0; prx_q <= 1'b0;
            armed_q <= 1'b0; done <= 1'b0; data <= '0; perr <= 1'b0; ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (line) armed_q <= 1'b1;
                    if (tick && !line && armed_q) begin
                        st_q <= ST_START; sub_q <= '0; armed_q <= 1'b0;
                    end
                end
                ST_START: if (tick) begin
                    if (sub_q == SUB_W'(OVS / 2 - 1)) begin
                        sub_q <= '0;
                        if (line) st_q <= ST_IDLE;
                        else begin st_q <= ST_DATA; bitn_q <= '0; end
                    end else sub_q <= sub_q + SUB_W'(1);
                end
                default: if (tick) begin
                    if (sub_q != SUB_W'(OVS - 1)) begin
                        sub_q <= sub_q + SUB_W'(1);
                    end else begin
                        sub_q <= '0;
                        if (st_q == ST_DATA) begin
                            sh_q <= {line, sh_q[7:1]};
                            if (bitn_q == last) st_q <= par_en ? ST_PAR : ST_STOP;
                            else                bitn_q <= bitn_q + 3'd1;
                        end else if (st_q == ST_PAR) begin
                            prx_q <= line;
                            st_q  <= ST_STOP;
                        end else begin
                            done <= 1'b1;
                            data <= aligned;
                            ferr <= !line;
                            perr <= par_en &&
                                    (prx_q != frame_parity(aligned, wlen, par_even, par_stick));
                            st_q <= ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sport_top.sv
// Serial port register block: host register map, line and modem status,
// interrupt ranking and loopback routing around the baud, transmit and
// receive engines. Assumes one strobe per access and a synchronous host.
module sport_top
    import sport_pkg::*;
#(
    parameter int OVS  = 16,
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    input  logic       ser_in,
    output logic       ser_out,
    input  logic       cts_in,
    input  logic       dsr_in,
    input  logic       ri_in,
    input  logic       dcd_in,
    output logic       dtr_out,
    output logic       rts_out,
    output logic       out1_out,
    output logic       out2_out
);
    localparam int DIV_W = 16;

    logic [7:0]      lcr_q, scr_q, dll_q, dlm_q, rbr_q, thr_q;
    logic [4:0]      mcr_q;
    logic [3:0]      ier_q, msr_now, msr_dlt, msr_raw, msr_chg;
    logic            thr_full, dr_q, oe_q, pe_q, fe_q, thre_int;
    logic [SYNC-1:0] sync_q;
    logic            dlab, loop, tick, tx_take, tx_line_raw, tx_line, tx_busy;
    logic            rx_line, rx_done, rx_perr, rx_ferr;
    logic [7:0]      rx_data, lsr_val, iir_val;
    logic            rls_p, rda_p, thr_p, ms_p, pending;
    logic [2:0]      code;
    logic            wr_thr, rd_rbr, rd_iir, rd_lsr, rd_msr;

    assign dlab   = lcr_q[7];
    assign loop   = mcr_q[4];
    assign wr_thr = wr_en && addr == OFF_DATA && !dlab;
    assign rd_rbr = rd_en && addr == OFF_DATA && !dlab;
    assign rd_iir = rd_en && addr == OFF_IIR;
    assign rd_lsr = rd_en && addr == OFF_LSR;
    assign rd_msr = rd_en && addr == OFF_MSR;

    sport_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor({dlm_q, dll_q}), .tick(tick));

    sport_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(thr_full), .data(thr_q),
        .wlen(lcr_q[1:0]), .stop2(lcr_q[2]), .par_en(lcr_q[3]), .par_even(lcr_q[4]),
        .par_stick(lcr_q[5]), .take(tx_take), .line(tx_line_raw), .busy(tx_busy));

    sport_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(rx_line), .wlen(lcr_q[1:0]),
        .par_en(lcr_q[3]), .par_even(lcr_q[4]), .par_stick(lcr_q[5]),
        .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr));

    // Line routing: break forces space; loopback keeps the pin at mark.
    assign tx_line  = lcr_q[6] ? 1'b0 : tx_line_raw;
    assign ser_out  = loop ? 1'b1 : tx_line;
    assign rx_line  = loop ? tx_line : sync_q[SYNC-1];
    assign dtr_out  = !loop && mcr_q[0];
    assign rts_out  = !loop && mcr_q[1];
    assign out1_out = !loop && mcr_q[2];
    assign out2_out = !loop && mcr_q[3];

    // Handshake sources in status order {DCD, RI, DSR, CTS}.
    assign msr_raw = loop ? {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1]}
                          : {dcd_in, ri_in, dsr_in, cts_in};
    assign msr_chg = {msr_raw[3] ^ msr_now[3], msr_now[2] & !msr_raw[2],
                      msr_raw[1] ^ msr_now[1], msr_raw[0] ^ msr_now[0]};

    // Interrupt ranking: line errors, data, transmit empty, modem.
    assign rls_p = ier_q[2] && (oe_q || pe_q || fe_q);
    assign rda_p = ier_q[0] && dr_q;
    assign thr_p = ier_q[1] && thre_int;
    assign ms_p  = ier_q[3] && (msr_dlt != '0);
    assign pending = rls_p || rda_p || thr_p || ms_p;
    always_comb begin
        if (rls_p)      code = CODE_LINE;
        else if (rda_p) code = CODE_RXD;
        else if (thr_p) code = CODE_THRE;
        else            code = CODE_MDM;
    end
    assign iir_val = pending ? {5'b0, code} : 8'h01;
    assign irq     = pending && mcr_q[3];
    assign lsr_val = {1'b0, !thr_full && !tx_busy, !thr_full, 1'b0, fe_q, pe_q, oe_q, dr_q};

    // Read multiplexer (no side effects here).
    always_comb begin
        unique case (addr)
            OFF_DATA: rdata = dlab ? dll_q : rbr_q;
            OFF_IER:  rdata = dlab ? dlm_q : {4'b0, ier_q};
            OFF_IIR:  rdata = iir_val;
            OFF_LCR:  rdata = lcr_q;
            OFF_MCR:  rdata = {3'b0, mcr_q};
            OFF_LSR:  rdata = lsr_val;
            OFF_MSR:  rdata = {msr_now, msr_dlt};
            default:  rdata = scr_q;
        endcase
    end

    // Host-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr_q <= '0; mcr_q <= '0; ier_q <= '0; scr_q <= '0;
            dll_q <= '0; dlm_q <= '0; thr_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                OFF_DATA: if (dlab) dll_q <= wdata; else thr_q <= wdata;
                OFF_IER:  if (dlab) dlm_q <= wdata; else ier_q <= wdata[3:0];
                OFF_LCR:  lcr_q <= wdata;
                OFF_MCR:  mcr_q <= wdata[4:0];
                OFF_SCR:  scr_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Status flags: set by engines, cleared by host reads and writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_full <= 1'b0; thre_int <= 1'b0; rbr_q <= '0;
            dr_q <= 1'b0; oe_q <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0;
            msr_now <= '0; msr_dlt <= '0; sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], ser_in};
            if (tx_take) begin thr_full <= 1'b0; thre_int <= 1'b1; end
            if (wr_en && addr == OFF_IER && !dlab && wdata[1] && !ier_q[1] && !thr_full)
                thre_int <= 1'b1;
            if (rd_iir && pending && code == CODE_THRE) thre_int <= 1'b0;
            if (wr_thr) begin thr_full <= 1'b1; thre_int <= 1'b0; end
            if (rd_rbr) dr_q <= 1'b0;
            if (rd_lsr) begin oe_q <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0; end
            if (rx_done) begin
                rbr_q <= rx_data;
                dr_q  <= 1'b1;
                if (dr_q && !rd_rbr) oe_q <= 1'b1;
                if (rx_perr) pe_q <= 1'b1;
                if (rx_ferr) fe_q <= 1'b1;
            end
            msr_now <= msr_raw;
            msr_dlt <= (rd_msr ? 4'b0 : msr_dlt) | msr_chg;
        end
    end
endmodule

// File: rtl/sport_checker.sv
// Checker: temporal properties of the serial port, bound to sport_top.
module sport_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rdata,
    input logic       irq,
    input logic       ser_out,
    input logic       dtr_out,
    input logic       rts_out,
    input logic [4:0] mcr_q,
    input logic [7:0] lcr_q,
    input logic [3:0] ier_q,
    input logic       dr_q,
    input logic       oe_q,
    input logic       pe_q,
    input logic       fe_q,
    input logic       rx_done,
    input logic       thr_full
);
    logic rd_rbr;
    assign rd_rbr = rd_en && addr == 3'd0 && !lcr_q[7];

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mcr_q[3]);
    assert_loop_pins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mcr_q[4] |-> (ser_out && !dtr_out && !rts_out));
    assert_break_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr_q[6] && !mcr_q[4]) |-> !ser_out);
    assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && dr_q && !rd_rbr) |=> oe_q);
    assert_ready_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> dr_q);
    assert_line_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd2 && ier_q[2] && (oe_q || pe_q || fe_q)) |-> rdata == 8'h06);
    assert_thr_fill_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && !lcr_q[7]) |=> thr_full);
endmodule

bind sport_top sport_checker i_sport_checker (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .irq(irq), .ser_out(ser_out), .dtr_out(dtr_out),
    .rts_out(rts_out), .mcr_q(mcr_q), .lcr_q(lcr_q), .ier_q(ier_q),
    .dr_q(dr_q), .oe_q(oe_q), .pe_q(pe_q), .fe_q(fe_q), .rx_done(rx_done),
    .thr_full(thr_full));

// File: tb/test_sport_top.sv
// Directed bench for sport_top: one task per scenario, divisor 1.
module test_sport_top;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       irq, ser_in = 1'b1, ser_out;
    logic       cts_in = 1'b0, dsr_in = 1'b0, ri_in = 1'b0, dcd_in = 1'b0;
    logic       dtr_out, rts_out, out1_out, out2_out;
    int         checks = 0, errors = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    sport_top i_sport_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq), .ser_in(ser_in), .ser_out(ser_out),
        .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in),
        .dtr_out(dtr_out), .rts_out(rts_out), .out1_out(out1_out), .out2_out(out2_out));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
        chk(req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one frame on ser_in, 16 clocks per bit.
    task automatic send_frame(input int nbits, input logic [7:0] d, input bit has_par,
                              input bit pbit, input bit stopb);
        @(negedge clk); ser_in = 1'b0; idle(16);
        for (int i = 0; i < nbits; i++) begin ser_in = d[i]; idle(16); end
        if (has_par) begin ser_in = pbit; idle(16); end
        ser_in = stopb; idle(16);
        ser_in = 1'b1; idle(20);
    endtask

    task automatic t_reset;
        chk("R13 ser_out idle", {7'b0, ser_out}, 8'h01);
        chk("R10 irq at reset", {7'b0, irq}, 8'h00);
        rd_chk(3'd2, 8'h01, "R13 IIR at reset");
        rd_chk(3'd5, 8'h60, "R13 LSR at reset");
        rd_chk(3'd3, 8'h00, "R1 LCR at reset");
    endtask

    task automatic t_regs;
        wr(3'd3, 8'h80); wr(3'd0, 8'h34); wr(3'd1, 8'h12);
        rd_chk(3'd0, 8'h34, "R2 divisor low");
        rd_chk(3'd1, 8'h12, "R2 divisor high");
        wr(3'd0, 8'h01); wr(3'd1, 8'h00); wr(3'd3, 8'h03);
        rd_chk(3'd1, 8'h00, "R2 IER untouched");
        rd_chk(3'd5, 8'h60, "R2 THR untouched");
        wr(3'd7, 8'hA7); rd_chk(3'd7, 8'hA7, "R1 scratch");
        wr(3'd4, 8'h07); rd_chk(3'd4, 8'h07, "R1 MCR readback");
        chk("R1 modem pins", {5'b0, out1_out, rts_out, dtr_out}, 8'h07);
        wr(3'd4, 8'h00);
        rd_chk(3'd3, 8'h03, "R1 LCR readback");
    endtask

    // Send one byte and check every bit on ser_out at its middle.
    task automatic t_tx(input logic [7:0] lcr, input logic [7:0] d);
        int n = 0, nb;
        logic [7:0] m; logic p;
        nb = 5 + int'(lcr[1:0]);
        m = 8'hFF >> (3 - lcr[1:0]);
        p = lcr[5] ? !lcr[4] : (lcr[4] ? ^(d & m) : !(^(d & m)));
        wr(3'd3, lcr); wr(3'd0, d);
        while (ser_out !== 1'b0 && n < 100) begin @(negedge clk); n++; end
        idle(8);
        chk("R3 start bit", {7'b0, ser_out}, 8'h00);
        for (int i = 0; i < nb; i++) begin
            idle(16); chk("R3 data bit", {7'b0, ser_out}, {7'b0, d[i]});
        end
        if (lcr[3]) begin idle(16); chk("R3 parity bit", {7'b0, ser_out}, {7'b0, p}); end
        idle(16); chk("R3 stop bit", {7'b0, ser_out}, 8'h01);
        if (lcr[2]) begin idle(16); chk("R3 second stop", {7'b0, ser_out}, 8'h01); end
        idle(20);
        rd_chk(3'd5, 8'h60, "R13 LSR after send");
    endtask

    task automatic t_break;
        wr(3'd3, 8'h43); idle(2);
        chk("R4 break low", {7'b0, ser_out}, 8'h00);
        wr(3'd3, 8'h03); idle(2);
        chk("R4 break released", {7'b0, ser_out}, 8'h01);
    endtask

    task automatic t_rx;
        wr(3'd3, 8'h1B);
        send_frame(8, 8'h3C, 1'b1, 1'b0, 1'b1);
        rd_chk(3'd5, 8'h61, "R5 data ready");
        rd_chk(3'd0, 8'h3C, "R5 received byte");
        rd_chk(3'd5, 8'h60, "R5 ready cleared");
        send_frame(8, 8'h0F, 1'b1, 1'b1, 1'b1);
        rd_chk(3'd5, 8'h65, "R6 parity error");
        rd_chk(3'd5, 8'h61, "R6 error cleared by read");
        rd_chk(3'd0, 8'h0F, "R6 byte kept");
        wr(3'd3, 8'h03);
        send_frame(8, 8'h5A, 1'b0, 1'b0, 1'b0);
        rd_chk(3'd5, 8'h69, "R6 framing error");
        rd_chk(3'd0, 8'h5A, "R6 framed byte");
        send_frame(8, 8'h11, 1'b0, 1'b0, 1'b1);
        send_frame(8, 8'h22, 1'b0, 1'b0, 1'b1);
        rd_chk(3'd5, 8'h63, "R7 overrun");
        rd_chk(3'd0, 8'h22, "R7 newest byte kept");
        rd_chk(3'd5, 8'h60, "R7 cleared");
    endtask

    task automatic t_thre;
        wr(3'd1, 8'h02); idle(1);
        chk("R10 gated without OUT2", {7'b0, irq}, 8'h00);
        wr(3'd4, 8'h08); idle(1);
        chk("R10 irq with OUT2", {7'b0, irq}, 8'h01);
        rd_chk(3'd2, 8'h02, "R9 THRE code");
        rd_chk(3'd2, 8'h01, "R9 cleared by IIR read");
        chk("R10 irq dropped", {7'b0, irq}, 8'h00);
        wr(3'd0, 8'h55); idle(3);
        rd_chk(3'd2, 8'h02, "R9 set when byte moves to shifter");
        idle(200);
        wr(3'd1, 8'h00); wr(3'd4, 8'h00);
    endtask

    task automatic t_prio;
        wr(3'd1, 8'h07);
        send_frame(8, 8'hA1, 1'b0, 1'b0, 1'b0);
        rd_chk(3'd2, 8'h06, "R8 line status first");
        rd_chk(3'd5, 8'h69, "R8 line status read");
        rd_chk(3'd2, 8'h04, "R8 data next");
        rd_chk(3'd0, 8'hA1, "R8 data read");
        rd_chk(3'd2, 8'h02, "R8 transmit empty last");
        rd_chk(3'd2, 8'h01, "R8 none pending");
        wr(3'd1, 8'h00);
    endtask

    task automatic t_modem;
        rd_chk(3'd6, 8'h00, "R11 quiet inputs");
        cts_in = 1'b1; idle(2);
        rd_chk(3'd6, 8'h11, "R11 CTS change");
        rd_chk(3'd6, 8'h10, "R11 delta cleared");
        wr(3'd1, 8'h08); wr(3'd4, 8'h08);
        ri_in = 1'b1; idle(2);
        ri_in = 1'b0; idle(2);
        rd_chk(3'd2, 8'h00, "R8 modem code");
        chk("R11 modem irq", {7'b0, irq}, 8'h01);
        rd_chk(3'd6, 8'h14, "R11 RI trailing edge");
        rd_chk(3'd2, 8'h01, "R11 cleared by status read");
        wr(3'd1, 8'h00); wr(3'd4, 8'h00);
        cts_in = 1'b0; idle(2);
        rd_chk(3'd6, 8'h01, "R11 CTS fall");
    endtask

    task automatic t_loop;
        logic [7:0] v;
        int bad = 0;
        wr(3'd4, 8'h1F); idle(2);
        @(negedge clk); addr = 3'd6; rd_en = 1'b1; #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
        chk("R12 outputs to inputs", {4'b0, v[7:4]}, 8'h0F);
        chk("R12 pins inactive", {5'b0, ser_out, dtr_out, out2_out}, 8'h04);
        wr(3'd3, 8'h03); wr(3'd0, 8'hC3);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (ser_out !== 1'b1) bad++;
        end
        chk("R12 ser_out at mark", 8'(bad), 8'h00);
        rd_chk(3'd5, 8'h61, "R12 byte looped back");
        rd_chk(3'd0, 8'hC3, "R12 looped byte value");
        wr(3'd4, 8'h00);
    endtask

    initial begin
        idle(3); rst_n = 1'b1; idle(2);
        t_reset;
        t_regs;
        t_tx(8'h1E, 8'h53);
        t_tx(8'h38, 8'h1F);
        t_tx(8'h03, 8'hA5);
        t_break;
        t_rx;
        t_thre;
        t_prio;
        t_modem;
        t_loop;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule